// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is a combinational integer ALU paired with a 4-bit condition status register. It adds, subtracts, ANDs or XORs two operands and drives the result on a port. From that result it derives four condition bits: negative, zero, carry and signed overflow. A result write-enable tells the surrounding pipeline whether the result should be stored.

Each of the four plain operations writes the status register only when its set-flags input is high. Four compare-style opcodes perform the same arithmetic or logic. They always refresh the status register and never raise the write-enable, so software can test values without a spare destination. For subtraction the carry bit means "no borrow", which is set when the first operand is unsigned-greater-or-equal to the second. The logic operations leave carry and overflow untouched.

The data width is a parameter that defaults to 32. The asynchronous active-low reset is released to the status register through a short synchronizer.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 (add) drives `result_o` = (opa + opb) mod 2^WIDTH, and opcode 4 (compare-add) drives the same value.
- R2: Opcode 1 (subtract) and opcode 5 (compare-subtract) drive `result_o` = (opa - opb) mod 2^WIDTH.
- R3: Opcodes 2 and 6 drive the bitwise AND of the operands, and opcodes 3 and 7 drive the bitwise XOR.
- R4: `flags_o` is {N,Z,C,V} in bits 3..0. After an updating operation, the next clock edge loads N with the result's top bit and Z with 1 exactly when the result is all zeros.
- R5: For add and compare-add, C is the carry out of the top bit, and V is 1 when both operands share a sign that differs from the result's sign. For example, 0xFFFFFFFF + 1 gives N=0 Z=1 C=1 V=0, and 0x7FFFFFFF + 0x7FFFFFFF gives 0xFFFFFFFE with C=0 V=1.
- R6: For subtract and compare-subtract, C is 1 exactly when opa >= opb as unsigned numbers. V is 1 when the operand signs differ and the result's sign differs from opa's sign.
- R7: An updating AND, XOR, AND-test or XOR-test leaves C and V at their previous values.
- R8: With `valid_i` low, or with opcodes 0..3 and `set_flags_i` low, `flags_o` keeps its value across the clock edge.
- R9: Opcodes 4..7 with `valid_i` high update the flags whatever the value of `set_flags_i`, and hold `result_we_o` low.
- R10: Reset clears `flags_o` to 0000. `result_we_o` equals `valid_i` for opcodes 0..3 and is never high while `valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Opcode; bit 2 selects the compare form, bits 1..0 select add/sub/and/xor |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| set_flags_i | input | 1 | Flag update request for opcodes 0..3 |
| valid_i | input | 1 | Operation strobe |
| result_o | output | WIDTH | Combinational result |
| result_we_o | output | 1 | Result write-enable |
| flags_o | output | 4 | Registered {N,Z,C,V} |

## Verification
The bench builds two copies of the block. A 4-bit copy is swept over every opcode, every operand pair and both set-flags values. At that width each carry, borrow and overflow boundary occurs, and every flag combination is reached from many different prior flag states, so the hold behaviour of C and V for the logic operations is exercised thoroughly. A 32-bit copy, at the default width, runs the same stimulus with each 4-bit operand mapped onto a 32-bit corner value such as 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. Idle cycles with the strobe low are interleaved throughout.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [1:0] {
    K_ADD = 2'd0,
    K_SUB = 2'd1,
    K_AND = 2'd2,
    K_XOR = 2'd3
  } alu_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cond_t;

  localparam int unsigned OP_W = 3;
endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [1:0]       kind,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res,
  output logic             is_logic,
  output cond_t            cond
);
  localparam int unsigned MSB = WIDTH - 1;

  alu_kind_e       k;
  logic            sub;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum;

  assign k     = alu_kind_e'(kind);
  assign sub   = (k == K_SUB);
  assign b_eff = sub ? ~b : b;
  assign sum   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};

  always_comb begin
    unique case (k)
      K_ADD, K_SUB: res = sum[MSB:0];
      K_AND:        res = a & b;
      default:      res = a ^ b;
    endcase
  end

  assign is_logic = kind[1];
  assign cond.n   = res[MSB];
  assign cond.z   = ~|res;
  assign cond.c   = sum[WIDTH];
  assign cond.v   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import flag_alu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_en,
  input  logic  keep_cv,
  input  cond_t cond_in,
  output cond_t cond_q
);
  cond_t cond_d;

  always_comb begin
    cond_d = cond_q;
    if (upd_en) begin
      cond_d.n = cond_in.n;
      cond_d.z = cond_in.z;
      if (!keep_cv) begin
        cond_d.c = cond_in.c;
        cond_d.v = cond_in.v;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= '0;
    else        cond_q <= cond_d;
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             set_flags_i,
  input  logic             valid_i,
  output logic [WIDTH-1:0] result_o,
  output logic             result_we_o,
  output logic [3:0]       flags_o
);
  logic  rst_n_int;
  logic  is_cmp;
  logic  upd;
  logic  logic_op;
  cond_t cond_new;
  cond_t cond_q;

  alu_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .kind     (op_i[1:0]),
    .a        (opa_i),
    .b        (opb_i),
    .res      (result_o),
    .is_logic (logic_op),
    .cond     (cond_new)
  );

  assign is_cmp      = op_i[2];
  assign upd         = valid_i & (is_cmp | set_flags_i);
  assign result_we_o = valid_i & ~is_cmp;

  alu_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .upd_en  (upd),
    .keep_cv (logic_op),
    .cond_in (cond_new),
    .cond_q  (cond_q)
  );

  assign flags_o = cond_q;
endmodule

// File: rtl/flag_alu_checker.sv
module flag_alu_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op_i,
  input logic             set_flags_i,
  input logic             valid_i,
  input logic [WIDTH-1:0] result_o,
  input logic             result_we_o,
  input logic [3:0]       flags_o
);
  logic upd;
  assign upd = valid_i && (op_i[2] || set_flags_i);

  a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flags_o[2] == ($past(result_o) == '0));

  a_r4_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flags_o[3] == $past(result_o[WIDTH-1]));

  a_r7_cv_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op_i[1]) |=> $stable(flags_o[1:0]));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags_o));

  a_r9_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i[2]) |-> !result_we_o);

  a_r10_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !result_we_o);
endmodule

bind flag_alu flag_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_i        (op_i),
  .set_flags_i (set_flags_i),
  .valid_i     (valid_i),
  .result_o    (result_o),
  .result_we_o (result_we_o),
  .flags_o     (flags_o)
);

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [31:0] a32 = '0, b32 = '0;
  logic        sf = 1'b0, valid = 1'b0;
  logic [3:0]  r4;
  logic [31:0] r32;
  logic        we4, we32;
  logic [3:0]  fl4, fl32;
  logic [3:0]  m4, m32;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  flag_alu #(.WIDTH(4)) u_flag_alu (
    .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(a4), .opb_i(b4),
    .set_flags_i(sf), .valid_i(valid), .result_o(r4), .result_we_o(we4), .flags_o(fl4));

  flag_alu #(.WIDTH(32)) u_flag_alu_w32 (
    .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(a32), .opb_i(b32),
    .set_flags_i(sf), .valid_i(valid), .result_o(r32), .result_we_o(we32), .flags_o(fl32));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] widen(input logic [3:0] v);
    case (v)
      4'd0:  return 32'h0000_0000;
      4'd1:  return 32'h0000_0001;
      4'd2:  return 32'h7FFF_FFFF;
      4'd3:  return 32'h8000_0000;
      4'd4:  return 32'hFFFF_FFFF;
      4'd5:  return 32'h8000_0001;
      4'd6:  return 32'h7FFF_FFFE;
      4'd7:  return 32'h5555_5555;
      4'd8:  return 32'hAAAA_AAAA;
      4'd9:  return 32'h0000_FFFF;
      4'd10: return 32'hFFFF_0000;
      4'd11: return 32'h1234_5678;
      4'd12: return 32'hFFFF_FFFE;
      4'd13: return 32'h4000_0000;
      4'd14: return 32'hC000_0000;
      default: return 32'h0F0F_0F0F;
    endcase
  endfunction

  // Returns {flags, result}; reference built on a widened sum
  function automatic logic [35:0] model(input int w, input logic [2:0] o,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0] old);
    logic [31:0] mask, bx, r;
    logic [63:0] s;
    logic n, z, c, v;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    c = old[1];
    v = old[0];
    bx = b;
    case (o[1:0])
      2'd0, 2'd1: begin
        bx = o[0] ? (~b & mask) : b;
        s = {32'd0, a} + {32'd0, bx} + {63'd0, o[0]};
        r = s[31:0] & mask;
        c = s[w];
        v = (a[w-1] == bx[w-1]) && (r[w-1] != a[w-1]);
      end
      2'd2: r = a & b;
      default: r = a ^ b;
    endcase
    n = r[w-1];
    z = (r == 32'd0);
    return {n, z, c, v, r};
  endfunction

  task automatic step(input logic [2:0] o, input logic [3:0] x, input logic [3:0] y,
                      input logic s, input logic vl);
    logic [35:0] e4, e32;
    logic upd;
    string req;
    @(negedge clk);
    op = o; a4 = x; b4 = y; a32 = widen(x); b32 = widen(y); sf = s; valid = vl;
    #1;
    e4  = model(4, o, {28'd0, x}, {28'd0, y}, m4);
    e32 = model(32, o, widen(x), widen(y), m32);
    req = (o[1:0] == 2'd0) ? "R1" : (o[1:0] == 2'd1) ? "R2" : "R3";
    chk(r4 == e4[3:0], req, {28'd0, r4}, {28'd0, e4[3:0]});
    chk(r32 == e32[31:0], req, r32, e32[31:0]);
    chk(we4 == (vl && !o[2]), o[2] ? "R9" : "R10", {31'd0, we4}, {31'd0, vl && !o[2]});
    chk(we32 == (vl && !o[2]), o[2] ? "R9" : "R10", {31'd0, we32}, {31'd0, vl && !o[2]});
    upd = vl && (o[2] || s);
    if (upd) begin
      m4  = e4[35:32];
      m32 = e32[35:32];
    end
    @(negedge clk);
    if (!upd)                   req = "R8";
    else if (o[1])              req = "R7";
    else if (o[2] && !s)        req = "R9";
    else if (o[0])              req = "R6";
    else                        req = "R5";
    chk(fl4 == m4, req, {28'd0, fl4}, {28'd0, m4});
    chk(fl32 == m32, (req == "R5" || req == "R6") ? req : "R4", {28'd0, fl32}, {28'd0, m32});
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m4 = '0; m32 = '0;
    repeat (3) @(negedge clk);
    chk(fl4 == 4'b0000, "R10", {28'd0, fl4}, 32'd0);
    chk(fl32 == 4'b0000, "R10", {28'd0, fl32}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(fl4 == 4'b0000, "R10", {28'd0, fl4}, 32'd0);
    // R5 directed: all-ones plus one -> N=0 Z=1 C=1 V=0
    step(3'd0, 4'd4, 4'd1, 1'b1, 1'b1);
    chk(fl32 == 4'b0110, "R5", {28'd0, fl32}, 32'h6);
    // R5 directed: max positive doubled -> 0xFFFFFFFE, N=1 V=1 C=0
    step(3'd0, 4'd2, 4'd2, 1'b1, 1'b1);
    chk(fl32 == 4'b1001, "R5", {28'd0, fl32}, 32'h9);
    // R6 directed: equal operands subtract -> Z=1 C=1
    step(3'd5, 4'd11, 4'd11, 1'b0, 1'b1);
    chk(fl32 == 4'b0110, "R6", {28'd0, fl32}, 32'h6);
    // R7 directed: XOR test keeps C=1 V=0
    step(3'd7, 4'd3, 4'd0, 1'b0, 1'b1);
    chk(fl32 == 4'b1010, "R7", {28'd0, fl32}, 32'hA);
    for (int o = 0; o < 8; o++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int s = 0; s < 2; s++) begin
            step(3'(o), 4'(x), 4'(y), 1'(s), 1'b1);
            if (((x + y + o) % 7) == 0) step(3'(o), 4'(y), 4'(x), 1'b1, 1'b0);
          end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule